// File: doc/BRIEF.md
# In-Order Completion Buffer

This block tracks instructions that have been dispatched but not yet retired, and it makes sure they leave in program order. Each dispatched instruction claims one entry through the allocate stream. The entry stores the instruction's tag and sits at the tail of a circular buffer of `DEPTH` entries. Execution units report a finished instruction by presenting its tag on the completion port. The buffer searches every valid entry for that tag and marks the match as done.

Each cycle the buffer looks at the oldest entries, starting at the head. It retires the run of done entries it finds there, up to `RET_MAX` of them, and stops at the first entry that is not done. The retire outputs are computed from registered state. They show the count and the tags of the entries that leave at the coming clock edge, so a completion reported at one edge can retire at the next edge at the earliest. The free and used counts and the full flag let the dispatch logic hold back issue.

The allocate interface is valid/ready. `alloc_ready` is high whenever at least one entry is free, and it depends on registered state only. A beat transfers on a clock edge where both `alloc_valid` and `alloc_ready` are high. `alloc_valid` asserted while `alloc_ready` is low is dropped, not held. The completion port and the retire outputs have no back-pressure. `DEPTH` must be a power of two.

Top module: `cmpl_buffer`

## Requirements
- R1: After reset `free_count` is DEPTH (16), `used_count` is 0, `full` is 0, `retire_count` is 0 and every entry is empty.
- R2: A transfer on the allocate interface stores `alloc_tag` at the tail as a not-done entry. With no retirement in that cycle, `used_count` rises by one and `free_count` falls by one.
- R3: `full` and `!alloc_ready` hold exactly when `free_count` is 0. An allocation attempted while full changes no count, and its tag never retires.
- R4: A completion sets the done mark of the valid entry whose tag equals `cmpl_tag`. A tag that matches no valid entry is ignored, and an entry allocated at the same edge is not yet valid for matching.
- R5: Retirement takes entries from the head in allocation order. It stops at the first entry that is not done, even if younger entries are done.
- R6: At most RET_MAX (5) entries retire per cycle.
- R7: An entry completed at a clock edge appears in `retire_count` no earlier than the cycle after that edge.
- R8: `retire_count` gives the number of entries retiring at the next edge. Slot k of `retire_tags`, bits [k*TAG_W +: TAG_W], holds the tag of the k-th oldest of them, with slot 0 the head. Unused slots read 0.
- R9: When an allocation and retirements happen in the same cycle, the counts change by their net amount: used' = used + alloc − retired.
- R10: The head and tail indices wrap modulo DEPTH, and program order is kept across the wrap.
- R11: `free_count + used_count` always equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate request valid |
| alloc_ready | output | 1 | An entry is free; a beat transfers when valid and ready are both high |
| alloc_tag | input | TAG_W (6) | Tag of the instruction being dispatched |
| cmpl_valid | input | 1 | Completion report valid |
| cmpl_tag | input | TAG_W (6) | Tag of the instruction that finished |
| retire_count | output | $clog2(RET_MAX+1) (3) | Number of entries retiring at the next edge |
| retire_tags | output | RET_MAX*TAG_W (30) | Tags retiring, oldest in slot 0 |
| free_count | output | $clog2(DEPTH+1) (5) | Number of unused entries |
| used_count | output | $clog2(DEPTH+1) (5) | Number of occupied entries |
| full | output | 1 | No free entry |

## Verification
The bench completes a younger entry ahead of an older one and checks that nothing retires until the head is done. A design that scanned past an incomplete entry would let instructions leave out of order. It fills the buffer, completes all sixteen entries in reverse order and then watches the drain run five, five, five and one. A design without the per-cycle cap, or one that fed `retire_tags` from the wrong slots, would show the wrong counts or the wrong tag order across the index wrap. It also presents a completion in the same cycle as the matching allocation, presents an unknown tag, tries to allocate while full, and allocates while retiring. Each of these catches a design that marks entries too early, accepts a phantom tag, overwrites live entries, or loses the net count update.

// File: rtl/cb_pkg.sv
package cb_pkg;
  parameter int CB_DEPTH   = 16;
  parameter int CB_TAG_W   = 6;
  parameter int CB_RET_MAX = 5;
endpackage

// File: rtl/cb_tag_match.sv
module cb_tag_match #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 6
) (
  input  logic                   en,
  input  logic [TAG_W-1:0]       key,
  input  logic [DEPTH-1:0]       valid,
  input  logic [DEPTH*TAG_W-1:0] tags,
  output logic [DEPTH-1:0]       hit
);
  // One comparator per entry; tags are unique among valid entries.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = en && valid[i] && (tags[i*TAG_W +: TAG_W] == key);
  end
endmodule

// File: rtl/cb_retire_scan.sv
module cb_retire_scan #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 6,
  parameter int RET_MAX = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RC_W   = $clog2(RET_MAX + 1)
) (
  input  logic [IDX_W-1:0]         head,
  input  logic [CNT_W-1:0]         used,
  input  logic [DEPTH-1:0]         valid,
  input  logic [DEPTH-1:0]         done,
  input  logic [DEPTH*TAG_W-1:0]   tags,
  output logic [RC_W-1:0]          count,
  output logic [RET_MAX*TAG_W-1:0] rtags,
  output logic [DEPTH-1:0]         rmask
);
  // Walk from the head; the first entry that is not done ends the run.
  always_comb begin
    logic             go;
    logic [IDX_W-1:0] idx;
    go    = 1'b1;
    idx   = '0;
    count = '0;
    rtags = '0;
    rmask = '0;
    for (int k = 0; k < RET_MAX; k++) begin
      idx = head + IDX_W'(k);
      if (go && (CNT_W'(k) < used) && valid[idx] && done[idx]) begin
        count                    = count + RC_W'(1);
        rmask[idx]               = 1'b1;
        rtags[k*TAG_W +: TAG_W]  = tags[idx*TAG_W +: TAG_W];
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmpl_buffer.sv
module cmpl_buffer #(
  parameter int DEPTH   = cb_pkg::CB_DEPTH,
  parameter int TAG_W   = cb_pkg::CB_TAG_W,
  parameter int RET_MAX = cb_pkg::CB_RET_MAX,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RC_W   = $clog2(RET_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [TAG_W-1:0]         alloc_tag,
  input  logic                     cmpl_valid,
  input  logic [TAG_W-1:0]         cmpl_tag,
  output logic [RC_W-1:0]          retire_count,
  output logic [RET_MAX*TAG_W-1:0] retire_tags,
  output logic [CNT_W-1:0]         free_count,
  output logic [CNT_W-1:0]         used_count,
  output logic                     full
);
  logic [DEPTH-1:0]       ent_valid;
  logic [DEPTH-1:0]       ent_done;
  logic [DEPTH*TAG_W-1:0] ent_tags;
  logic [DEPTH-1:0]       hit;
  logic [DEPTH-1:0]       ret_mask;
  logic [IDX_W-1:0]       head_q, tail_q;
  logic [CNT_W-1:0]       used_q, free_q;
  logic                   alloc_fire;

  assign alloc_ready = (free_q != '0);
  assign full        = (free_q == '0);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign free_count  = free_q;
  assign used_count  = used_q;

  cb_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .en    (cmpl_valid),
    .key   (cmpl_tag),
    .valid (ent_valid),
    .tags  (ent_tags),
    .hit   (hit)
  );

  cb_retire_scan #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RET_MAX(RET_MAX)) u_scan (
    .head  (head_q),
    .used  (used_q),
    .valid (ent_valid),
    .done  (ent_done),
    .tags  (ent_tags),
    .count (retire_count),
    .rtags (retire_tags),
    .rmask (ret_mask)
  );

  // Per-entry state: allocation, then retirement, then completion marking.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i]               <= 1'b0;
        ent_done[i]                <= 1'b0;
        ent_tags[i*TAG_W +: TAG_W] <= '0;
      end else if (alloc_fire && (tail_q == IDX_W'(i))) begin
        ent_valid[i]               <= 1'b1;
        ent_done[i]                <= 1'b0;
        ent_tags[i*TAG_W +: TAG_W] <= alloc_tag;
      end else if (ret_mask[i]) begin
        ent_valid[i]               <= 1'b0;
        ent_done[i]                <= 1'b0;
        ent_tags[i*TAG_W +: TAG_W] <= '0;
      end else if (hit[i]) begin
        ent_done[i]                <= 1'b1;
      end
    end
  end

  // Pointers and occupancy; indices wrap through IDX_W-bit truncation.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      used_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      head_q <= head_q + IDX_W'(retire_count);
      if (alloc_fire) tail_q <= tail_q + IDX_W'(1);
      used_q <= used_q + CNT_W'(alloc_fire) - CNT_W'(retire_count);
      free_q <= free_q - CNT_W'(alloc_fire) + CNT_W'(retire_count);
    end
  end
endmodule

// File: rtl/cb_checks.sv
module cb_checks #(
  parameter int DEPTH   = 16,
  parameter int RET_MAX = 5,
  parameter int CNT_W   = 5,
  parameter int RC_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [RC_W-1:0]  retire_count,
  input logic [CNT_W-1:0] free_count,
  input logic [CNT_W-1:0] used_count,
  input logic             full
);
  assert_count_sum_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) + int'(used_count) == DEPTH);

  assert_full_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> used_count <= $past(used_count));

  assert_retire_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_count) <= RET_MAX);

  assert_retire_within_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_count) <= int'(used_count));

  assert_net_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(used_count) == int'($past(used_count))
             + ($past(alloc_valid && alloc_ready) ? 1 : 0)
             - int'($past(retire_count)));
endmodule

bind cmpl_buffer cb_checks #(
  .DEPTH(DEPTH), .RET_MAX(RET_MAX), .CNT_W(CNT_W), .RC_W(RC_W)
) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .retire_count (retire_count),
  .free_count   (free_count),
  .used_count   (used_count),
  .full         (full)
);

// File: tb/sim_cmpl_buffer.sv
module sim_cmpl_buffer;
  localparam int TAG_W = 6;
  localparam int NVEC  = 8;
  // fields: alloc_v[27] alloc_tag[26:21] cmpl_v[20] cmpl_tag[19:14]
  //         exp_rc[13:11] exp_used[10:6] exp_tag0[5:0]
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 6'd10, 1'b0, 6'd0,  3'd0, 5'd0, 6'd0},
    {1'b1, 6'd11, 1'b1, 6'd10, 3'd0, 5'd1, 6'd0},
    {1'b1, 6'd12, 1'b1, 6'd12, 3'd1, 5'd2, 6'd10},
    {1'b0, 6'd0,  1'b1, 6'd12, 3'd0, 5'd2, 6'd0},
    {1'b0, 6'd0,  1'b1, 6'd11, 3'd0, 5'd2, 6'd0},
    {1'b0, 6'd0,  1'b0, 6'd0,  3'd2, 5'd2, 6'd11},
    {1'b0, 6'd0,  1'b1, 6'd55, 3'd0, 5'd0, 6'd0},
    {1'b0, 6'd0,  1'b0, 6'd0,  3'd0, 5'd0, 6'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, cmpl_valid;
  logic [5:0]  alloc_tag, cmpl_tag;
  logic        alloc_ready, full;
  logic [2:0]  retire_count;
  logic [29:0] retire_tags;
  logic [4:0]  free_count, used_count;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmpl_buffer u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .retire_count(retire_count), .retire_tags(retire_tags),
    .free_count(free_count), .used_count(used_count), .full(full)
  );

  task automatic eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rtag(input int k);
    return int'(retire_tags[k*TAG_W +: TAG_W]);
  endfunction

  // Drive one cycle's inputs at the falling edge; outputs settle 1 ns later.
  task automatic cyc(input bit av, input int at, input bit cv, input int ct);
    @(negedge clk);
    alloc_valid = av;
    alloc_tag   = 6'(at);
    cmpl_valid  = cv;
    cmpl_tag    = 6'(ct);
    #1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_tag = '0; cmpl_valid = 1'b0; cmpl_tag = '0;
    repeat (3) @(posedge clk);
    #1;
    eq("R1 free after reset", free_count, 16);
    eq("R1 used after reset", used_count, 0);
    eq("R1 full after reset", full, 0);
    eq("R1 retire after reset", retire_count, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: completion timing, in-order stop, unknown tag.
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      cyc(v[27], int'(v[26:21]), v[20], int'(v[19:14]));
      eq("R5/R7 retire count", retire_count, int'(v[13:11]));
      eq("R2/R4 used count", used_count, int'(v[10:6]));
      if (v[13:11] != 0) eq("R8 head retire tag", rtag(0), int'(v[5:0]));
      if (i == 5) eq("R8 second retire tag", rtag(1), 12);
    end

    // Fill to full across the index wrap.
    for (int t = 20; t < 36; t++) cyc(1'b1, t, 1'b0, 0);
    cyc(1'b1, 63, 1'b0, 0);
    eq("R3 full flag", full, 1);
    eq("R3 alloc_ready low", alloc_ready, 0);
    eq("R3 used at full", used_count, 16);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R3 dropped alloc", used_count, 16);
    eq("R11 free at full", free_count, 0);

    // Complete youngest first: nothing may retire until the head is done.
    for (int t = 35; t > 20; t--) begin
      cyc(1'b0, 0, 1'b1, t);
      eq("R5 no retire past head", retire_count, 0);
    end
    cyc(1'b0, 0, 1'b1, 20);
    eq("R7 not same cycle", retire_count, 0);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R6 capped at five", retire_count, 5);
    for (int k = 0; k < 5; k++) eq("R8 R10 tag order", rtag(k), 20 + k);
    cyc(1'b1, 40, 1'b0, 0);
    eq("R6 second burst", retire_count, 5);
    eq("R8 second burst head", rtag(0), 25);
    eq("R9 used before net", used_count, 11);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R9 net update", used_count, 7);
    eq("R11 free net", free_count, 9);
    eq("R8 third burst head", rtag(0), 30);
    eq("R8 third burst tail", rtag(4), 34);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R5 stop at incomplete", retire_count, 1);
    eq("R8 last filled tag", rtag(0), 35);
    eq("R8 unused slot zero", rtag(1), 0);
    eq("R9 used", used_count, 2);
    cyc(1'b0, 0, 1'b1, 40);
    eq("R5 waiting entry", retire_count, 0);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R4 R10 wrapped entry", retire_count, 1);
    eq("R10 wrapped tag", rtag(0), 40);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R3 ignored tag absent", used_count, 0);
    eq("R3 ignored tag no retire", retire_count, 0);
    eq("R11 drained free", free_count, 16);

    // Reset while occupied.
    cyc(1'b1, 1, 1'b0, 0);
    cyc(1'b1, 2, 1'b0, 0);
    @(negedge clk);
    alloc_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    eq("R1 used after mid reset", used_count, 0);
    eq("R1 free after mid reset", free_count, 16);
    rst_n = 1'b1;
    cyc(1'b0, 0, 1'b1, 1);
    cyc(1'b0, 0, 1'b0, 0);
    eq("R1 entries cleared", retire_count, 0);

    summary();
    $finish;
  end
endmodule